// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synchronous static memory of 36-bit words, organised as four 9-bit byte lanes (eight data bits plus one parity bit each). A new access begins when one of two active-low address strobes is accepted: one intended for a processor and one for a bus controller. On that edge the address is registered and its two lowest bits seed a two-bit burst counter. Later cycles either write the current word, lane by lane or all at once, or read it. An active-low step input moves the counter through the four words of the aligned group in linear order, wrapping at the end of the group.

Read data is registered. The word read at one rising edge appears after that edge. The data outputs are not a real tri-state pad. A separate drive-enable output says when the word should reach the shared bus. It follows an asynchronous active-low output enable and stays off for the first read after the device is reselected from a deselected state. Three chip selects of mixed polarity are sampled only on address-load edges. A sleep input freezes all state and keeps the memory contents.

Top module: `sram_burst_core`

## Requirements
- R1: After reset the device is deselected. No read or write takes place and `rdata_oe` is 0 until a selecting address load occurs.
- R2: An accepted strobe causes a load edge. On that edge the address is captured only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If any select is not asserted, the device is deselected and no access occurs until the next selecting load.
- R3: `strobe_cpu_n` has no effect while `sel_a_n` is 1. `strobe_ctl_n` still causes a load in that case, and so deselects the device. When both strobes are low and `sel_a_n` is 0, the processor strobe governs and exactly one load takes place.
- R4: The chip selects are sampled only on load edges. Changing them during a burst does not interrupt the burst.
- R5: A selecting load sets the word offset to `addr_i[1:0]`. Each access edge with `step_n`=0 increments the offset modulo 4 (for example 2,3,0,1). The upper address bits do not change.
- R6: Writes happen on access edges, meaning active, non-load and non-sleep edges, at the current address. `wr_all_n`=0 writes all four lanes whatever `wr_byte_n` and `lane_n` are. Write inputs on a load edge are ignored.
- R7: Otherwise lane k, which is `wdata` bits 9k+8 down to 9k, is written only when `wr_byte_n`=0 and `lane_n[k]`=0.
- R8: An access edge that writes no lane is a read. The word at the current address appears on `rdata` after that edge.
- R9: `rdata_oe` is 1 only while `oe_n` is 0 and the most recent non-sleep edge was a read. It responds to `oe_n` without waiting for a clock edge.
- R10: For the first access after a selecting load made while deselected, `rdata_oe` is held at 0 even with `oe_n` low. It is driven normally from the next read on.
- R11: While `sleep` is 1, no load, step, write or read occurs, the memory contents are kept, and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, sampled on load edges |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, gated by `sel_a_n` |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Retention mode, active high |
| wdata | input | 36 | Write word, four 9-bit lanes |
| rdata | output | 36 | Registered read word |
| rdata_oe | output | 1 | Drive enable for `rdata` |

## Verification
The bench builds the core with ADDR_W=6, which gives a 64-word array. At that size every word can be written and read back, with a burst starting at each possible low-bit offset so that every wrap point is covered. All sixteen lane-select patterns are then written to a single word, the strobe and chip-select combinations are run through, and the deselect, reselect and sleep sequences are exercised. A shadow copy of the array and a small model of the current address, select state and first-read mask, both updated from the requirements alone, supply each expected word and drive-enable value.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES_DEF  = 4;
  localparam int LANE_W_DEF = 9;
  localparam int ADDR_W_DEF = 10;
  localparam int OFS_W      = 2;
endpackage

// File: rtl/sram_addr_ctrl.sv
module sram_addr_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              access,
  output logic              fresh
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic            cpu_take, ctl_take, load_req, hit;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic            act_q, act_d, fresh_q, fresh_d;

  // processor strobe gated by the first select; it wins over the controller
  always_comb begin
    cpu_take = !strobe_cpu_n && !sel_a_n;
    ctl_take = !strobe_ctl_n && !cpu_take;
    load_req = (cpu_take || ctl_take) && !sleep;
    hit      = !sel_a_n && sel_b && !sel_c_n;
    access   = act_q && !load_req && !sleep;
  end

  always_comb begin
    hi_d    = hi_q;
    ofs_d   = ofs_q;
    act_d   = act_q;
    fresh_d = fresh_q;
    if (load_req) begin
      act_d = hit;
      if (hit) begin
        hi_d    = addr_i[ADDR_W-1:OFS_W];
        ofs_d   = addr_i[OFS_W-1:0];
        fresh_d = !act_q;
      end
    end else if (access) begin
      fresh_d = 1'b0;
      if (!step_n) ofs_d = ofs_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      ofs_q   <= '0;
      act_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      hi_q    <= hi_d;
      ofs_q   <= ofs_d;
      act_q   <= act_d;
      fresh_q <= fresh_d;
    end
  end

  assign cur_addr = {hi_q, ofs_q};
  assign fresh    = fresh_q;

  a_r3_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe_cpu_n && sel_a_n && strobe_ctl_n && step_n)
      |=> ($stable(cur_addr) && $stable(act_q)));

  a_r5_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !step_n) |=> (ofs_q == $past(ofs_q) + 2'd1) && $stable(hi_q));

  a_r4_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> act_q);

  a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cur_addr) && $stable(act_q) && $stable(fresh_q)));
endmodule

// File: rtl/sram_wr_dec.sv
module sram_wr_dec
  import sram_pkg::*;
#(
  parameter int LANES = LANES_DEF
) (
  input  logic             access,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] wmask,
  output logic             rd_now
);
  always_comb begin
    wmask = '0;
    if (access) begin
      if (!wr_all_n)       wmask = '1;
      else if (!wr_byte_n) wmask = ~lane_n;
    end
    rd_now = access && (wmask == '0);
  end
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wmask,
  input  logic                    rd_now,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wmask[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_now) rd_q <= bank[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

  a_r8_no_rw_clash: assert property (@(posedge clk)
    rd_now |-> (wmask == '0));
endmodule

// File: rtl/sram_burst_core.sv
module sram_burst_core
  import sram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  logic [ADDR_W-1:0] cur_addr;
  logic              access, fresh, rd_now;
  logic [LANES-1:0]  wmask;
  logic              valid_q, valid_d, mask_q, mask_d;

  sram_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .step_n(step_n),
    .cur_addr(cur_addr), .access(access), .fresh(fresh)
  );

  sram_wr_dec #(.LANES(LANES)) u_dec (
    .access(access), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_n), .wmask(wmask), .rd_now(rd_now)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .addr(cur_addr), .wmask(wmask), .rd_now(rd_now),
    .wdata(wdata), .rdata(rdata)
  );

  always_comb begin
    valid_d = valid_q;
    mask_d  = mask_q;
    if (!sleep) begin
      valid_d = rd_now;
      mask_d  = rd_now && fresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  assign rdata_oe = !oe_n && valid_q && !mask_q && !sleep;

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !sleep) |=> valid_q);

  a_r10_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && fresh) |=> !rdata_oe);

  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask != '0) |=> !rdata_oe);
endmodule

// File: tb/tb_sram_burst_core.sv
`timescale 1ns/1ps
module tb_sram_burst_core;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr_i;
  logic strobe_cpu_n, strobe_ctl_n, sel_a_n, sel_b, sel_c_n, step_n;
  logic wr_all_n, wr_byte_n, oe_n, sleep;
  logic [3:0] lane_n;
  logic [35:0] wdata, rdata;
  logic rdata_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [35:0] sh [DEPTH];
  logic [AW-1:0] m_addr;
  bit m_act, m_fresh;

  always #2 clk = ~clk;

  sram_burst_core #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [35:0] pat(int a, int salt);
    logic [35:0] w;
    for (int k = 0; k < 4; k++) w[k*9 +: 9] = 9'((a * 5 + k * 61 + salt) % 512);
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; sleep = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] a);
    return {a[AW-1:2], a[1:0] + 2'd1};
  endfunction

  task automatic do_load(logic [AW-1:0] a, bit cpu, bit ctl, bit s1n, bit s2, bit s3n);
    bit take, hit;
    addr_i = a; strobe_cpu_n = !cpu; strobe_ctl_n = !ctl;
    sel_a_n = s1n; sel_b = s2; sel_c_n = s3n;
    tick();
    take = (cpu && !s1n) || ctl;
    hit  = !s1n && s2 && !s3n;
    if (take) begin
      if (hit) begin
        m_fresh = !m_act;
        m_addr  = a;
      end
      m_act = hit;
    end
    idle();
  endtask

  task automatic do_write(bit gw_n, bit bw_n, logic [3:0] ln, logic [35:0] d, bit stp);
    logic [3:0] m;
    wr_all_n = gw_n; wr_byte_n = bw_n; lane_n = ln; wdata = d; step_n = !stp;
    tick();
    m = !gw_n ? 4'hF : (!bw_n ? ~ln : 4'h0);
    if (m_act) begin
      for (int k = 0; k < 4; k++) if (m[k]) sh[m_addr][k*9 +: 9] = d[k*9 +: 9];
      m_fresh = 0;
      if (stp) m_addr = nxt(m_addr);
    end
    idle();
  endtask

  task automatic do_read(bit stp, string req);
    logic [AW-1:0] a;
    bit eoe;
    step_n = !stp;
    tick();
    a = m_addr;
    eoe = m_act && !oe_n && !m_fresh;
    if (m_act) begin
      chk(rdata === sh[a], req, rdata, sh[a]);
      m_fresh = 0;
      if (stp) m_addr = nxt(m_addr);
    end
    chk(rdata_oe === eoe, req, 36'(rdata_oe), 36'(eoe));
    idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    addr_i = '0; wdata = '0; oe_n = 0;
    m_act = 0; m_fresh = 0; m_addr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: deselected after reset, no drive
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(rdata_oe === 1'b0, "R1", 36'(rdata_oe), 36'd0);
    end

    // R5/R6: fill every word in bursts starting at each offset
    for (int g = 0; g < DEPTH / 4; g++) begin
      do_load(AW'(g * 4 + g % 4), g % 2 == 0, g % 2 == 1, 0, 1, 0);
      for (int j = 0; j < 4; j++) do_write(0, 1, 4'hF, pat(g * 4 + (g + j) % 4, 3), 1);
    end
    // R8/R5: read everything back in wrapped bursts
    for (int g = 0; g < DEPTH / 4; g++) begin
      do_load(AW'(g * 4 + (g + 2) % 4), 0, 1, 0, 1, 0);
      for (int j = 0; j < 4; j++) do_read(1, "R8 R5 burst read");
    end
    // R5: reading without step stays on one word
    do_load(AW'(9), 1, 0, 0, 1, 0);
    do_read(0, "R5 hold");
    do_read(0, "R5 hold");

    // R7: every lane pattern on one word
    for (int p = 0; p < 16; p++) begin
      do_load(AW'(21), 1, 0, 0, 1, 0);
      do_write(1, 0, ~4'(p), pat(p, 100), 0);
      do_read(0, "R7 lane select");
    end
    // R7: lane selects without the lane enable write nothing
    do_load(AW'(22), 1, 0, 0, 1, 0);
    do_write(1, 1, 4'h0, 36'hABCDE1234, 0);
    do_read(0, "R7 no enable");
    // R6: global write overrides disabled lane controls
    do_write(0, 1, 4'hF, 36'h123456789, 0);
    do_read(0, "R6 global");
    // R6: write inputs on a load edge are ignored
    wr_all_n = 0; wdata = 36'hFFFFFFFFF;
    do_load(AW'(30), 0, 1, 0, 1, 0);
    do_read(0, "R6 load edge");

    // R3: processor strobe ignored while sel_a_n high
    do_load(AW'(40), 1, 0, 0, 1, 0);
    do_load(AW'(50), 1, 0, 1, 1, 0);
    do_read(0, "R3 cpu gated");
    // R3: both strobes low: processor governs, single load
    do_load(AW'(45), 1, 1, 0, 1, 0);
    do_read(1, "R3 both strobes");
    do_read(1, "R3 both strobes");
    // R3/R2: controller strobe with sel_a_n high deselects
    do_load(AW'(12), 0, 1, 1, 1, 0);
    do_read(1, "R3 ctl deselect");
    do_write(0, 1, 4'hF, 36'h0, 0);
    // R10: reselect; first access masked, then driven
    do_load(AW'(12), 0, 1, 0, 1, 0);
    do_read(1, "R10 first masked");
    do_read(1, "R10 second driven");
    // R2: deselect through the high select, then through sel_c_n
    do_load(AW'(3), 1, 0, 0, 0, 0);
    do_read(0, "R2 sel_b low");
    do_load(AW'(3), 0, 1, 0, 1, 1);
    do_read(0, "R2 sel_c_n high");
    do_load(AW'(3), 1, 0, 0, 1, 0);
    do_read(1, "R2 reselect masked");
    do_read(1, "R2 reselect");

    // R4: selects change mid burst without effect
    do_load(AW'(60), 0, 1, 0, 1, 0);
    do_read(1, "R4 start");
    for (int j = 0; j < 3; j++) begin
      sel_a_n = 1; sel_b = 0; sel_c_n = 1; step_n = 0;
      tick();
      chk(rdata === sh[m_addr] && rdata_oe === 1'b1, "R4 burst", rdata, sh[m_addr]);
      m_addr = nxt(m_addr);
      idle();
    end

    // R9: drive enable follows oe_n without a clock
    do_load(AW'(33), 1, 0, 0, 1, 0);
    do_read(0, "R9 read");
    oe_n = 1; #0.5;
    chk(rdata_oe === 1'b0, "R9 oe off", 36'(rdata_oe), 36'd0);
    oe_n = 0; #0.5;
    chk(rdata_oe === 1'b1, "R9 oe on", 36'(rdata_oe), 36'd1);

    // R11: sleep freezes load, step and write
    sleep = 1; wr_all_n = 0; step_n = 0; wdata = 36'h5A5A5A5A5;
    strobe_ctl_n = 0; addr_i = AW'(7);
    tick();
    chk(rdata_oe === 1'b0, "R11 sleep drive", 36'(rdata_oe), 36'd0);
    tick();
    chk(rdata_oe === 1'b0, "R11 sleep drive", 36'(rdata_oe), 36'd0);
    idle();
    do_read(0, "R11 after sleep");
    do_read(0, "R11 after sleep");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule